// File: doc/BRIEF.md
# Dual Storage Element with Selectable Flip-Flop or Latch Behaviour

This block holds a small group of storage bits (two by default) that share one element clock pin, one clock enable and one set/reset input. Static configuration inputs choose whether the bits act as rising-edge flip-flops or as latches that are open while the element clock is low. They also choose whether set/reset is synchronous or asynchronous, and whether the top bypass pin serves as an alternate reset that forces the complementary value. Each bit picks its data input from either a combinational source or a bypass pin, and has its own set/reset value.

The block runs on a fast system clock `clk`. The element clock `eclk` is treated as a sampled signal: its rising edges and its low level are detected once per system clock. Every update becomes visible on `q` one system clock after the condition is sampled. A global initialise strobe loads every bit from its init bit. A global capture strobe copies the present state of every bit into its init bit. Both strobes are sampled on `clk`. After reset, the init bits and the storage bits all hold the parameter `INIT_DEFAULT`.

Top module: `ffp_pair`

## Requirements
- R1: After reset is released, `q` and `init_q` both equal `INIT_DEFAULT`.
- R2: With `cfg_latch`=0 and `ce`=1, a low-to-high transition of `eclk` loads each bit with its selected data input, visible one `clk` cycle later. Without such a transition, `q` holds.
- R3: With `ce`=0, neither an `eclk` rising edge (flip-flop mode) nor a low `eclk` (latch mode) changes `q`.
- R4: With `cfg_latch`=1 and `ce`=1, `q` follows the selected data one `clk` cycle behind while `eclk` is low, and holds while `eclk` is high.
- R5: For bit i, `cfg_dsel[i]`=0 selects `comb[i]` and `cfg_dsel[i]`=1 selects `byp[i]`.
- R6: With `cfg_sr_en`=1 and `cfg_sync`=0, `sr`=1 loads each bit with `cfg_srval[i]` on the next `clk` cycle, regardless of `eclk`. With `cfg_sr_en`=0, `sr` has no effect.
- R7: With `cfg_sync`=1, set/reset acts only at an `eclk` rising edge, and at that edge it wins over `ce`=0.
- R8: With `cfg_rev_en`=1, `byp[ELEMS-1]`=1 loads each bit with the inverse of `cfg_srval[i]`, under the same asynchronous or synchronous timing as set/reset. With `cfg_rev_en`=0, that pin forces nothing.
- R9: When set/reset and the alternate reset are both active, each bit takes `cfg_srval[i]`.
- R10: `gsr`=1 loads `q` from `init_q` on the next `clk` cycle. This takes priority over set/reset, the alternate reset and data.
- R11: `gcap`=1 copies `q` into `init_q` on the next `clk` cycle. A later `gsr` restores the captured value.
- R12: The combination `cfg_sync`=1 with `cfg_latch`=1 is illegal and must never be applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eclk | input | 1 | Element clock: rising edge in flip-flop mode, active-low gate in latch mode |
| ce | input | 1 | Active-high enable for the edge or the gate |
| sr | input | 1 | Set/reset request, loads `cfg_srval` |
| gsr | input | 1 | Global initialise strobe, loads init bits into `q` |
| gcap | input | 1 | Global capture strobe, copies `q` into init bits |
| comb | input | ELEMS | Combinational data source per bit |
| byp | input | ELEMS | Bypass data per bit; the top bit also serves as the alternate reset pin |
| cfg_latch | input | 1 | 1 = latch mode, 0 = flip-flop mode |
| cfg_sync | input | 1 | 1 = synchronous set/reset, 0 = asynchronous |
| cfg_sr_en | input | 1 | Enables `sr` |
| cfg_rev_en | input | 1 | Enables the alternate reset on `byp[ELEMS-1]` |
| cfg_srval | input | ELEMS | Per-bit set/reset value |
| cfg_dsel | input | ELEMS | Per-bit data select (0 comb, 1 bypass) |
| q | output | ELEMS | Stored bits |
| init_q | output | ELEMS | Per-bit init bits |

## Verification
The bench builds the block with `ELEMS`=3 and `INIT_DEFAULT`=3'b101. Three bits let each test pattern mix ones and zeros across bits, so per-bit set/reset values, per-bit data selects and the inversion under the alternate reset can each be told apart from a stuck or shared value. It also separates the top bit, whose bypass pin doubles as the alternate reset, from the lower bits. The asymmetric init pattern lets a load from the init bits be distinguished from a set/reset result.

// File: rtl/ffp_pkg.sv
package ffp_pkg;

  typedef enum logic {
    DSEL_COMB = 1'b0,
    DSEL_BYP  = 1'b1
  } dsel_e;

  // Shared per-cycle decisions, identical for every element.
  typedef struct packed {
    logic load_init;   // global initialise
    logic force_val;   // set/reset or alternate reset applies now
    logic pick_srval;  // 1: configured value, 0: its inverse
    logic take_d;      // data capture through edge or open gate
  } elem_ctl_t;

endpackage

// File: rtl/ffp_edge_det.sv
module ffp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic eclk,
  output logic rise
);

  logic eclk_d;
  logic eclk_d_n;

  always_comb begin
    eclk_d_n = eclk;
  end

  // Resets high so a pin already high at release is not seen as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eclk_d <= 1'b1;
    else        eclk_d <= eclk_d_n;
  end

  assign rise = eclk & ~eclk_d;

endmodule

// File: rtl/ffp_ctrl.sv
module ffp_ctrl
  import ffp_pkg::*;
(
  input  logic      rise,
  input  logic      eclk,
  input  logic      ce,
  input  logic      sr,
  input  logic      rev_pin,
  input  logic      gsr,
  input  logic      cfg_latch,
  input  logic      cfg_sync,
  input  logic      cfg_sr_en,
  input  logic      cfg_rev_en,
  output elem_ctl_t ctl
);

  logic sr_hit;
  logic rev_hit;
  logic force_ok;
  logic gate_open;

  always_comb begin
    sr_hit    = cfg_sr_en & sr;
    rev_hit   = cfg_rev_en & rev_pin;
    force_ok  = ~cfg_sync | rise;
    gate_open = cfg_latch ? ~eclk : rise;

    ctl.load_init  = gsr;
    ctl.force_val  = (sr_hit | rev_hit) & force_ok;
    ctl.pick_srval = sr_hit;
    ctl.take_d     = ce & gate_open;
  end

endmodule

// File: rtl/ffp_elem.sv
module ffp_elem
  import ffp_pkg::*;
#(
  parameter logic INIT_BIT = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  elem_ctl_t ctl,
  input  logic      gcap,
  input  logic      comb,
  input  logic      byp,
  input  logic      dsel,
  input  logic      srval,
  output logic      q,
  output logic      init_q
);

  logic d;
  logic q_n;
  logic init_n;

  always_comb begin
    d = (dsel_e'(dsel) == DSEL_BYP) ? byp : comb;

    q_n = q;
    if (ctl.load_init)      q_n = init_q;
    else if (ctl.force_val) q_n = ctl.pick_srval ? srval : ~srval;
    else if (ctl.take_d)    q_n = d;

    init_n = gcap ? q : init_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= INIT_BIT;
      init_q <= INIT_BIT;
    end else begin
      q      <= q_n;
      init_q <= init_n;
    end
  end

endmodule

// File: rtl/ffp_pair.sv
module ffp_pair
  import ffp_pkg::*;
#(
  parameter int              ELEMS        = 2,
  parameter logic [ELEMS-1:0] INIT_DEFAULT = {ELEMS{1'b0}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eclk,
  input  logic             ce,
  input  logic             sr,
  input  logic             gsr,
  input  logic             gcap,
  input  logic [ELEMS-1:0] comb,
  input  logic [ELEMS-1:0] byp,
  input  logic             cfg_latch,
  input  logic             cfg_sync,
  input  logic             cfg_sr_en,
  input  logic             cfg_rev_en,
  input  logic [ELEMS-1:0] cfg_srval,
  input  logic [ELEMS-1:0] cfg_dsel,
  output logic [ELEMS-1:0] q,
  output logic [ELEMS-1:0] init_q
);

  localparam int REV_IDX = ELEMS - 1;

  logic [1:0] rst_sync;
  logic       rst_s;
  logic       rise;
  elem_ctl_t  ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  assign rst_s = rst_sync[1];

  ffp_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_s),
    .eclk  (eclk),
    .rise  (rise)
  );

  ffp_ctrl u_ctrl (
    .rise       (rise),
    .eclk       (eclk),
    .ce         (ce),
    .sr         (sr),
    .rev_pin    (byp[REV_IDX]),
    .gsr        (gsr),
    .cfg_latch  (cfg_latch),
    .cfg_sync   (cfg_sync),
    .cfg_sr_en  (cfg_sr_en),
    .cfg_rev_en (cfg_rev_en),
    .ctl        (ctl)
  );

  for (genvar i = 0; i < ELEMS; i++) begin : g_elem
    ffp_elem #(
      .INIT_BIT (INIT_DEFAULT[i])
    ) u_elem (
      .clk    (clk),
      .rst_n  (rst_s),
      .ctl    (ctl),
      .gcap   (gcap),
      .comb   (comb[i]),
      .byp    (byp[i]),
      .dsel   (cfg_dsel[i]),
      .srval  (cfg_srval[i]),
      .q      (q[i]),
      .init_q (init_q[i])
    );
  end

endmodule

// File: rtl/ffp_pair_checker.sv
module ffp_pair_checker #(
  parameter int ELEMS = 2
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             ce,
  input logic             sr,
  input logic             gsr,
  input logic             gcap,
  input logic [ELEMS-1:0] byp,
  input logic             cfg_latch,
  input logic             cfg_sync,
  input logic             cfg_sr_en,
  input logic             cfg_rev_en,
  input logic [ELEMS-1:0] cfg_srval,
  input logic [ELEMS-1:0] q,
  input logic [ELEMS-1:0] init_q
);

  logic sr_on;
  logic rev_on;

  assign sr_on  = cfg_sr_en & sr;
  assign rev_on = cfg_rev_en & byp[ELEMS-1];

  a_r10_init_load: assert property (@(posedge clk) disable iff (!rst_ok)
    gsr |=> (q == $past(init_q)));

  a_r11_capture: assert property (@(posedge clk) disable iff (!rst_ok)
    gcap |=> (init_q == $past(q)));

  a_r6_async_sr: assert property (@(posedge clk) disable iff (!rst_ok)
    (sr_on && !cfg_sync && !gsr) |=> (q == $past(cfg_srval)));

  a_r8_alt_reset: assert property (@(posedge clk) disable iff (!rst_ok)
    (rev_on && !sr_on && !cfg_sync && !gsr) |=> (q == ~$past(cfg_srval)));

  a_r9_sr_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    (rev_on && sr_on && !cfg_sync && !gsr) |=> (q == $past(cfg_srval)));

  a_r3_ce_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ce && !gsr && !sr_on && !rev_on) |=> $stable(q));

  a_r12_no_sync_latch: assert property (@(posedge clk) disable iff (!rst_ok)
    !(cfg_sync && cfg_latch));

endmodule

bind ffp_pair ffp_pair_checker #(.ELEMS(ELEMS)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_s),
  .ce         (ce),
  .sr         (sr),
  .gsr        (gsr),
  .gcap       (gcap),
  .byp        (byp),
  .cfg_latch  (cfg_latch),
  .cfg_sync   (cfg_sync),
  .cfg_sr_en  (cfg_sr_en),
  .cfg_rev_en (cfg_rev_en),
  .cfg_srval  (cfg_srval),
  .q          (q),
  .init_q     (init_q)
);

// File: tb/ffp_pair_bench.sv
`timescale 1ns/1ps
module ffp_pair_bench;

  localparam int         N    = 3;
  localparam logic [N-1:0] INIT = 3'b101;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         eclk, ce, sr, gsr, gcap;
  logic [N-1:0] comb, byp, cfg_srval, cfg_dsel;
  logic         cfg_latch, cfg_sync, cfg_sr_en, cfg_rev_en;
  logic [N-1:0] q, init_q;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  ffp_pair #(.ELEMS(N), .INIT_DEFAULT(INIT)) u_ffp_pair (
    .clk(clk), .rst_n(rst_n), .eclk(eclk), .ce(ce), .sr(sr), .gsr(gsr),
    .gcap(gcap), .comb(comb), .byp(byp), .cfg_latch(cfg_latch),
    .cfg_sync(cfg_sync), .cfg_sr_en(cfg_sr_en), .cfg_rev_en(cfg_rev_en),
    .cfg_srval(cfg_srval), .cfg_dsel(cfg_dsel), .q(q), .init_q(init_q)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] got,
                     input logic [N-1:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; eclk = 1'b1; ce = 1'b0; sr = 1'b0; gsr = 1'b0; gcap = 1'b0;
    comb = '0; byp = '0; cfg_srval = '0; cfg_dsel = '0;
    cfg_latch = 1'b0; cfg_sync = 1'b0; cfg_sr_en = 1'b0; cfg_rev_en = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 q", q, INIT);
    chk("R1 init_q", init_q, INIT);
  endtask

  task automatic t_ff();
    ce = 1'b1; cfg_dsel = 3'b000; comb = 3'b010; byp = 3'b100;
    eclk = 1'b0; tick();
    chk("R2 no edge", q, INIT);
    eclk = 1'b1; tick();
    chk("R2 edge", q, 3'b010);
    comb = 3'b111; tick();
    chk("R2 hold", q, 3'b010);
    cfg_dsel = 3'b101; byp = 3'b001; comb = 3'b110;
    eclk = 1'b0; tick();
    eclk = 1'b1; tick();
    chk("R5 select", q, 3'b011);
  endtask

  task automatic t_ce();
    ce = 1'b0; cfg_dsel = 3'b000; comb = 3'b000;
    eclk = 1'b0; tick();
    eclk = 1'b1; tick();
    chk("R3 ff", q, 3'b011);
    cfg_latch = 1'b1; eclk = 1'b0; tick(); tick();
    chk("R3 latch", q, 3'b011);
    eclk = 1'b1; cfg_latch = 1'b0; ce = 1'b1; tick();
  endtask

  task automatic t_latch();
    cfg_latch = 1'b1; ce = 1'b1; cfg_dsel = 3'b000;
    eclk = 1'b0; comb = 3'b110; tick();
    chk("R4 open a", q, 3'b110);
    comb = 3'b001; tick();
    chk("R4 open b", q, 3'b001);
    eclk = 1'b1; tick();
    comb = 3'b111; tick();
    chk("R4 closed", q, 3'b001);
    eclk = 1'b0; tick();
    chk("R4 reopen", q, 3'b111);
    eclk = 1'b1; tick();
    cfg_latch = 1'b0;
  endtask

  task automatic t_async();
    cfg_sr_en = 1'b0; sr = 1'b1; cfg_srval = 3'b010; tick();
    chk("R6 disabled", q, 3'b111);
    cfg_sr_en = 1'b1; tick();
    chk("R6 async", q, 3'b010);
    sr = 1'b0; tick();
  endtask

  task automatic t_sync();
    cfg_sync = 1'b1; cfg_sr_en = 1'b1; cfg_srval = 3'b100; ce = 1'b0;
    sr = 1'b1; eclk = 1'b0; tick();
    chk("R7 wait edge", q, 3'b010);
    eclk = 1'b1; tick();
    chk("R7 edge over ce", q, 3'b100);
    sr = 1'b0; cfg_sync = 1'b0; tick();
  endtask

  task automatic t_rev();
    ce = 1'b0; cfg_sr_en = 1'b1; sr = 1'b0; cfg_rev_en = 1'b1;
    cfg_srval = 3'b110; byp = 3'b100; tick();
    chk("R8 inverse", q, 3'b001);
    cfg_rev_en = 1'b0; cfg_srval = 3'b001; tick();
    chk("R8 disabled", q, 3'b001);
    cfg_rev_en = 1'b1; sr = 1'b1; cfg_srval = 3'b010; tick();
    chk("R9 sr wins", q, 3'b010);
    sr = 1'b0; byp = 3'b000; cfg_rev_en = 1'b0; cfg_sr_en = 1'b0; tick();
  endtask

  task automatic t_gsr();
    cfg_sr_en = 1'b1; sr = 1'b1; cfg_srval = 3'b000; gsr = 1'b1; tick();
    chk("R10 init load", q, INIT);
    gsr = 1'b0; sr = 1'b0; cfg_sr_en = 1'b0; tick();
  endtask

  task automatic t_gcap();
    ce = 1'b1; cfg_dsel = 3'b000; comb = 3'b110;
    eclk = 1'b0; tick();
    eclk = 1'b1; tick();
    chk("R2 before capture", q, 3'b110);
    gcap = 1'b1; tick();
    chk("R11 capture", init_q, 3'b110);
    gcap = 1'b0; ce = 1'b0; cfg_sr_en = 1'b1; sr = 1'b1; cfg_srval = 3'b000; tick();
    chk("R6 clear", q, 3'b000);
    sr = 1'b0; cfg_sr_en = 1'b0; gsr = 1'b1; tick();
    chk("R11 restore", q, 3'b110);
    gsr = 1'b0; tick();
    chk("R11 init kept", init_q, 3'b110);
  endtask

  initial begin
    #(1_000_000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ff();
    t_ce();
    t_latch();
    t_async();
    t_sync();
    t_rev();
    t_gsr();
    t_gcap();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule